// File: doc/BRIEF.md
# Mode-Configured Port Direction Controller

This block owns the direction setting of a five-pin general-purpose port. Software writes a direction register that cannot be read back. Each of the five low bits turns one pin into an output when set and leaves it as an input when clear. A three-bit operating-mode input decides two things. It picks the value the register takes on power-on reset and in hardware standby. It also picks which pins carry an active-low chip-select instead of a bit of the port data register.

In software standby the chip-select pins follow a hold control. They either keep the level they had just before standby began, or they release the pin. Ordinary output pins keep driving the port data. The block sits between the bus write path, the chip-select decoder, the port data register and the pin pads.

Top module: `pin_dir_ctrl`

## Requirements
- R1: With `wr_en` high, `mrst_n` high, `sw_stby` low and `hw_stby` low, the direction register takes `wr_data[4:0]` at the next rising clock edge. `wr_data[7:5]` is dropped. A set bit n makes `pin_oe[n]` 1 whenever pin n is not released by R9.
- R2: `rd_data` is always 8'hFF.
- R3: While `por_n` is low, the direction register holds 5'b10000 when `mode` is 1, 4 or 5, and 5'b00000 for every other mode value, mode 0 included.
- R4: At each rising edge with `hw_stby` high, the direction register is reloaded with the R3 value for the current mode, and any write is ignored.
- R5: While `mrst_n` is low or `sw_stby` is high, the direction register keeps its contents and writes are ignored.
- R6: In modes 1 and 2, an enabled pin 4 drives `cs_n[0]`. Enabled pins 3 to 0 drive `port_data` bits 3 to 0.
- R7: In modes 4, 5 and 6, enabled pins 4, 3, 2 and 1 drive `cs_n[0]`, `cs_n[1]`, `cs_n[2]` and `cs_n[3]`. An enabled pin 0 drives `port_data[0]`.
- R8: In modes 0, 3 and 7, every enabled pin n drives `port_data[n]`.
- R9: While `sw_stby` is high and `stby_oe` is 0, every chip-select pin has `pin_oe` 0.
- R10: While `sw_stby` is high and `stby_oe` is 1, an enabled chip-select pin drives the level its `cs_n` bit had at the last rising edge before `sw_stby` went high. Later changes of `cs_n` have no effect until standby ends.
- R11: Pins that are not chip-select pins are unaffected by `sw_stby` and `stby_oe`.
- R12: A pin whose `pin_oe` is 0 drives `pin_out` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| stby_oe | input | 1 | 1 keeps chip-select pins driven in software standby |
| mode | input | 3 | Operating mode |
| cs_n | input | 4 | Internal active-low chip selects 0 to 3 |
| port_data | input | 5 | Port data register value |
| wr_en | input | 1 | Direction register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the direction register |
| pin_out | output | 5 | Pin output levels |
| pin_oe | output | 5 | Pin output enables |

## Verification
On every cycle the assertions check the following:
- the constant read value;
- the register load under hardware standby;
- the write path and the freeze under manual reset or software standby;
- chip-select release in standby;
- plain-port routing in the plain-I/O modes;
- the low level of undriven pins.

Some behaviours only the bench's scenarios can show:
- the per-mode reset values under power-on reset;
- the chip-select routing in the two chip-select groups;
- the level held across software standby while `cs_n` keeps changing.

The bench shows these by comparing every pin against its behavioural model on every clock.

// File: rtl/pin_dir_ctrl.sv
module pin_dir_ctrl #(
  parameter int NPIN = 5,
  parameter int NCS  = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            mrst_n,
  input  logic            hw_stby,
  input  logic            sw_stby,
  input  logic            stby_oe,
  input  logic [2:0]      mode,
  input  logic [NCS-1:0]  cs_n,
  input  logic [NPIN-1:0] port_data,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  localparam int TOP = NPIN - 1;

  logic [NPIN-1:0] dir;
  logic [NCS-1:0]  cs_hold;
  logic            grp_a, grp_b, rst_hi, wr_ok, cs_off;
  logic [NPIN-1:0] rst_val, is_cs, cs_live, cs_held, lvl, val;
  logic            unused_rsvd;

  assign grp_a  = (mode == 3'd1) || (mode == 3'd2);
  assign grp_b  = (mode == 3'd4) || (mode == 3'd5) || (mode == 3'd6);
  assign rst_hi = (mode == 3'd1) || (mode == 3'd4) || (mode == 3'd5);

  assign rst_val = rst_hi ? NPIN'(1 << TOP) : '0;
  assign wr_ok   = wr_en && mrst_n && !sw_stby && !hw_stby;
  assign unused_rsvd = ^wr_data[DW-1:NPIN];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       dir <= rst_val;
    else if (hw_stby) dir <= rst_val;
    else if (wr_ok)   dir <= wr_data[NPIN-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        cs_hold <= '1;
    else if (!sw_stby) cs_hold <= cs_n;
  end

  assign is_cs = grp_a ? NPIN'(1 << TOP) :
                 grp_b ? {{NCS{1'b1}}, 1'b0} : '0;

  assign cs_live[0] = 1'b1;
  assign cs_held[0] = 1'b1;
  for (genvar k = 0; k < NCS; k++) begin : g_cs_map
    assign cs_live[TOP-k] = cs_n[k];
    assign cs_held[TOP-k] = cs_hold[k];
  end

  assign cs_off = sw_stby && !stby_oe;
  assign lvl    = sw_stby ? cs_held : cs_live;
  assign val    = (is_cs & lvl) | (~is_cs & port_data);
  assign pin_oe = dir & ~(is_cs & {NPIN{cs_off}});
  assign pin_out = val & pin_oe;
  assign rd_data = '1;
endmodule

module pin_dir_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       mrst_n,
  input logic       hw_stby,
  input logic       sw_stby,
  input logic       stby_oe,
  input logic [2:0] mode,
  input logic [4:0] port_data,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [4:0] pin_out,
  input logic [4:0] pin_oe,
  input logic [4:0] dir
);
  AST_RD_ALL_ONES: assert property (@(posedge clk) disable iff (!por_n) rd_data == 8'hFF); // R2
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && mrst_n && !sw_stby && !hw_stby) |=> dir == $past(wr_data[4:0])); // R1
  AST_HW_RELOAD: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |=> dir == ((($past(mode) == 3'd1) || ($past(mode) == 3'd4) || ($past(mode) == 3'd5)) ? 5'b10000 : 5'b00000)); // R4
  AST_FROZEN_DIR: assert property (@(posedge clk) disable iff (!por_n)
    ((!mrst_n || sw_stby) && !hw_stby) |=> $stable(dir)); // R5
  AST_CS_RELEASED: assert property (@(posedge clk) disable iff (!por_n)
    (sw_stby && !stby_oe && (mode == 3'd4 || mode == 3'd5 || mode == 3'd6)) |-> pin_oe[4:1] == 4'b0000); // R9
  AST_PLAIN_ROUTE: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 3'd0 || mode == 3'd3 || mode == 3'd7) |-> pin_out == (port_data & pin_oe)); // R8
  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!por_n) (pin_out & ~pin_oe) == 5'b00000); // R12
endmodule

bind pin_dir_ctrl pin_dir_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
  .stby_oe(stby_oe), .mode(mode), .port_data(port_data), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .dir(dir)
);

// File: tb/pin_dir_ctrl_test.sv
module pin_dir_ctrl_test;
  logic clk = 0;
  logic por_n = 0, mrst_n = 1, hw_stby = 0, sw_stby = 0, stby_oe = 0, wr_en = 0;
  logic [2:0] mode = 3'd1;
  logic [3:0] cs_n = 4'hF;
  logic [4:0] port_data = 5'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [4:0] pin_out, pin_oe;

  int checks = 0, failures = 0;
  string phase = "R3";
  int m_dir = 0, m_hold = 15;

  always #4 clk = ~clk;

  pin_dir_ctrl uut (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .stby_oe(stby_oe), .mode(mode), .cs_n(cs_n), .port_data(port_data), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int rst_of(int md);
    return (md == 1 || md == 4 || md == 5) ? 16 : 0;
  endfunction

  function automatic int cs_of(int md, int p);
    if ((md == 1 || md == 2) && p == 4) return 0;
    if ((md >= 4 && md <= 6) && p >= 1) return 4 - p;
    return -1;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_dir = rst_of(mode);
      m_hold = 15;
    end else begin
      if (hw_stby) m_dir = rst_of(mode);
      else if (wr_en && mrst_n && !sw_stby) m_dir = wr_data & 8'h1F;
      if (!sw_stby) m_hold = cs_n;
    end
  end

  task automatic cmp(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic check_now();
    int eo = 0, ev = 0;
    int d = por_n ? m_dir : rst_of(mode);
    for (int p = 0; p < 5; p++) begin
      int c = cs_of(mode, p);
      int oe, lv;
      if (c >= 0) begin
        oe = ((d >> p) & 1) && !(sw_stby && !stby_oe);
        lv = sw_stby ? ((m_hold >> c) & 1) : ((cs_n >> c) & 1);
      end else begin
        oe = (d >> p) & 1;
        lv = (port_data >> p) & 1;
      end
      if (oe != 0) begin
        eo |= 1 << p;
        ev |= lv << p;
      end
    end
    cmp(pin_oe, eo, "pin_oe");
    cmp(pin_out, ev, "pin_out");
    cmp(rd_data, 8'hFF, "rd_data R2");
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1;
    wr_data = v;
    step(1);
    wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    phase = "R3";
    mode = 3'd5;
    step(2);
    mode = 3'd2;
    step(1);
    mode = 3'd0;
    step(1);
    mode = 3'd4;
    step(1);
    por_n = 1;
    step(2);

    phase = "R1";
    mode = 3'd3;
    port_data = 5'b10110;
    wr(8'hE5);
    step(2);
    port_data = 5'b01111;
    wr(8'hFF);
    step(1);
    port_data = 5'b10101;
    step(1);

    phase = "R12";
    wr(8'h0A);
    port_data = 5'b11111;
    step(2);

    phase = "R6";
    mode = 3'd1;
    wr(8'h1F);
    cs_n = 4'b1110;
    port_data = 5'b00110;
    step(1);
    cs_n = 4'b1111;
    step(1);
    mode = 3'd2;
    cs_n = 4'b1110;
    step(1);

    phase = "R7";
    mode = 3'd5;
    for (int k = 0; k < 4; k++) begin
      cs_n = ~(4'b1 << k);
      step(1);
    end
    mode = 3'd6;
    cs_n = 4'b0101;
    port_data = 5'b00001;
    step(1);

    phase = "R8";
    mode = 3'd7;
    port_data = 5'b11010;
    step(1);
    mode = 3'd0;
    port_data = 5'b00101;
    step(1);

    phase = "R4";
    mode = 3'd4;
    hw_stby = 1;
    wr_en = 1;
    wr_data = 8'h0F;
    step(2);
    wr_en = 0;
    mode = 3'd7;
    step(1);
    hw_stby = 0;
    step(1);

    phase = "R5";
    mode = 3'd3;
    wr(8'h15);
    mrst_n = 0;
    wr(8'h0A);
    step(1);
    mrst_n = 1;
    sw_stby = 1;
    wr(8'h0A);
    sw_stby = 0;
    step(1);

    phase = "R9";
    mode = 3'd6;
    wr(8'h1F);
    cs_n = 4'b1010;
    step(1);
    sw_stby = 1;
    stby_oe = 0;
    step(2);
    sw_stby = 0;
    step(1);

    phase = "R10";
    stby_oe = 1;
    cs_n = 4'b0110;
    step(1);
    sw_stby = 1;
    cs_n = 4'b1001;
    step(1);
    cs_n = 4'b0000;
    step(2);

    phase = "R11";
    port_data = 5'b00001;
    step(1);
    port_data = 5'b00000;
    stby_oe = 0;
    step(1);
    mode = 3'd7;
    port_data = 5'b10101;
    step(1);
    sw_stby = 0;
    step(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule